// File: doc/BRIEF.md
# Pilot-aided carrier phase recovery

This block removes a slowly drifting carrier phase from a stream of complex fixed-point symbols. The sender places a pair of known pilot symbols at the start of every frame. For each symbol, the block reads a coarse phase from a table. At the second pilot of a pair, it forms the circular mean of the two pilot phases, which gives one phase estimate per frame.

Once the estimates on both sides of a frame are known, each payload symbol of that frame gets a phase by linear interpolation between them. The symbol is then rotated back through a cosine/sine table and a complex multiply. The symbol data waits in a delay line so that each symbol meets the phase computed for that same symbol.

The pipeline advances only on accepted symbols, one per clock at most. A gap in the input therefore freezes all internal state. Pilots never reach the output, and no output is produced until two pilot pairs have been seen.

Top module: `cr_pilot_phase_rec`

## Requirements
- R1: While reset is asserted and after it is released, `valid_o` is low and `i_o`/`q_o` are zero until the first corrected symbol appears.
- R2: Symbol phase is held in PW-bit wrapping units of pi/2^(PW-1). Let ih and qh be the top AB bits of `i_i` and `q_i`, read as signed values. The table phase is round(atan2(2qh+1, 2ih+1)·2^(PW-1)/pi), taken modulo 2^PW. From this, the reference pilot phase 2^(PW-3) (the point 1+j) is subtracted.
- R3: Let a and b be the phases of the two pilots of a frame. The frame estimate is a + floor(s/2), where s is b−a taken modulo 2^PW and read as signed. The estimate therefore stays correct when the pair straddles ±pi.
- R4: Take payload symbol p of frame g, with estimates e_g and e_(g+1). Let d be e_(g+1)−e_g, wrapped and read as signed. The symbol's phase is e_g + floor(d·p/2^LOG2N), taken modulo 2^PW.
- R5: Let c = round(cos(phi)·2^(CW-2)) and s = round(sin(phi)·2^(CW-2)). The output is I' = (I·c + Q·s + 2^(CW-3)) >> (CW-2) and Q' = (Q·c − I·s + 2^(CW-3)) >> (CW-2), using an arithmetic shift. Each result is saturated to W signed bits.
- R6: A symbol accepted on one active edge leaves `valid_o` high right after the active edge that accepts the (2^LOG2N + 6)-th later symbol. `valid_o` is high only just after an edge at which `valid_i` was high.
- R7: No output appears until two pilot pairs have been received. Symbols before the first pilot pair and the pilot symbols themselves never appear on the output.
- R8: `i_o` and `q_o` hold their value in every cycle in which `valid_o` is low.
- R9: Frames are 2^LOG2N symbols long. `pilot_i` marks positions 0 and 1 of each frame, and positions 2 to 2^LOG2N−1 carry payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input symbol accepted this cycle |
| pilot_i | input | 1 | Input symbol is a pilot |
| i_i | input | W | In-phase component, signed |
| q_i | input | W | Quadrature component, signed |
| valid_o | output | 1 | Corrected payload symbol present |
| i_o | output | W | Corrected in-phase component, signed |
| q_o | output | W | Corrected quadrature component, signed |

## Verification
Latency is counted in accepted symbols, not in clock cycles. A payload symbol appears after the edge that accepts the 2^LOG2N+6-th symbol after it. In every cycle, the bench works out which earlier symbol is due from its own count of accepted inputs. It expects `valid_o` low and the data unchanged after edges with no accepted input.

Each expected value comes from symbols stored in the bench. The bench computes the pair estimates of the current and next frame from those symbols, so a one-symbol slip in the delay line or the phase path shows up as a mismatch. The runs include a drift across ±pi, random input gaps and large symbols that drive the output into saturation.

// File: rtl/cr_pkg.sv
package cr_pkg;
  localparam real PI = 3.14159265358979323846;

  function automatic int sx(int v, int bits);
    return (v >= (1 << (bits - 1))) ? v - (1 << bits) : v;
  endfunction

  // bin centre of the truncated components
  function automatic int atan_code(int ih, int qh, int pw);
    real r;
    r = $atan2(2.0 * qh + 1.0, 2.0 * ih + 1.0) / PI * (2.0 ** (pw - 1));
    return $rtoi($floor(r + 0.5));
  endfunction

  function automatic int trig_code(int ph, int pw, int cw, bit sine);
    real a;
    a = PI * ph / (2.0 ** (pw - 1));
    return $rtoi($floor((sine ? $sin(a) : $cos(a)) * (2.0 ** (cw - 2)) + 0.5));
  endfunction
endpackage

// File: rtl/cr_pilot_est.sv
module cr_pilot_est #(
  parameter int W  = 8,
  parameter int AB = 5,
  parameter int PW = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 pilot_i,
  input  logic signed [W-1:0]  i_i,
  input  logic signed [W-1:0]  q_i,
  output logic [PW-1:0]        est_old_o,
  output logic signed [PW-1:0] delta_o,
  output logic                 primed_o
);
  localparam int ROM = 1 << (2 * AB);
  localparam logic [PW-1:0] REF = PW'(1) << (PW - 3);

  logic [PW-1:0] rom [ROM];
  for (genvar a = 0; a < ROM; a++) begin : g_rom
    assign rom[a] = PW'(cr_pkg::atan_code(cr_pkg::sx(a >> AB, AB),
                                          cr_pkg::sx(a % (1 << AB), AB), PW));
  end

  logic [2*AB-1:0] addr;
  assign addr = {i_i[W-1 -: AB], q_i[W-1 -: AB]};

  logic          prev_pil, s1_pil, s1_sec, est_stb;
  logic [PW-1:0] s1_ph, prv_ph, est_new, est_cur;
  logic [1:0]    groups;
  logic signed [PW-1:0] pair_d, half_d;

  assign pair_d = s1_ph - prv_ph;
  assign half_d = pair_d >>> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_pil  <= 1'b0;
      s1_pil    <= 1'b0;
      s1_sec    <= 1'b0;
      s1_ph     <= '0;
      prv_ph    <= '0;
      est_stb   <= 1'b0;
      est_new   <= '0;
      est_cur   <= '0;
      est_old_o <= '0;
      delta_o   <= '0;
      groups    <= '0;
    end else if (en_i) begin
      prev_pil <= pilot_i;
      s1_ph    <= rom[addr] - REF;
      s1_pil   <= pilot_i;
      s1_sec   <= pilot_i & prev_pil;
      prv_ph   <= s1_ph;
      est_stb  <= s1_pil & s1_sec;
      if (s1_pil && s1_sec) est_new <= prv_ph + $unsigned(half_d);
      if (est_stb) begin
        est_cur   <= est_new;
        est_old_o <= est_cur;
        delta_o   <= est_new - est_cur;
        if (groups != 2'd2) groups <= groups + 1'b1;
      end
    end
  end

  assign primed_o = (groups == 2'd2);
endmodule

// File: rtl/cr_derot.sv
module cr_derot #(
  parameter int W  = 8,
  parameter int PW = 10,
  parameter int CW = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                ok_i,
  input  logic [PW-1:0]       ph_i,
  input  logic signed [W-1:0] i_i,
  input  logic signed [W-1:0] q_i,
  output logic                valid_o,
  output logic signed [W-1:0] i_o,
  output logic signed [W-1:0] q_o
);
  localparam int ROM = 1 << PW;
  localparam int PRW = W + CW;
  localparam int SW  = W + CW + 1;
  localparam logic signed [SW-1:0] RND  = SW'(1 << (CW - 3));
  localparam logic signed [SW-1:0] MAXV = SW'((1 << (W - 1)) - 1);
  localparam logic signed [SW-1:0] MINV = -SW'(1 << (W - 1));

  logic signed [CW-1:0] cos_rom [ROM];
  logic signed [CW-1:0] sin_rom [ROM];
  for (genvar a = 0; a < ROM; a++) begin : g_trig
    assign cos_rom[a] = CW'(cr_pkg::trig_code(a, PW, CW, 1'b0));
    assign sin_rom[a] = CW'(cr_pkg::trig_code(a, PW, CW, 1'b1));
  end

  logic                  ok2, ok3;
  logic signed [CW-1:0]  c2, s2;
  logic signed [W-1:0]   i2, q2;
  logic signed [PRW-1:0] p_ic, p_qs, p_qc, p_is;
  logic signed [SW-1:0]  sum_i, sum_q, sh_i, sh_q;

  assign sum_i = SW'(p_ic) + SW'(p_qs) + RND;
  assign sum_q = SW'(p_qc) - SW'(p_is) + RND;
  assign sh_i  = sum_i >>> (CW - 2);
  assign sh_q  = sum_q >>> (CW - 2);

  function automatic logic signed [W-1:0] sat(input logic signed [SW-1:0] v);
    if (v > MAXV) return MAXV[W-1:0];
    if (v < MINV) return MINV[W-1:0];
    return v[W-1:0];
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ok2 <= 1'b0; ok3 <= 1'b0;
      c2 <= '0; s2 <= '0; i2 <= '0; q2 <= '0;
      p_ic <= '0; p_qs <= '0; p_qc <= '0; p_is <= '0;
      valid_o <= 1'b0; i_o <= '0; q_o <= '0;
    end else begin
      valid_o <= en_i & ok3;
      if (en_i) begin
        c2   <= cos_rom[ph_i];
        s2   <= sin_rom[ph_i];
        i2   <= i_i;
        q2   <= q_i;
        ok2  <= ok_i;
        p_ic <= i2 * c2;
        p_qs <= q2 * s2;
        p_qc <= q2 * c2;
        p_is <= i2 * s2;
        ok3  <= ok2;
        if (ok3) begin
          i_o <= sat(sh_i);
          q_o <= sat(sh_q);
        end
      end
    end
  end
endmodule

// File: rtl/cr_pilot_phase_rec.sv
module cr_pilot_phase_rec #(
  parameter int W     = 8,
  parameter int AB    = 5,
  parameter int PW    = 10,
  parameter int CW    = 10,
  parameter int LOG2N = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic                pilot_i,
  input  logic signed [W-1:0] i_i,
  input  logic signed [W-1:0] q_i,
  output logic                valid_o,
  output logic signed [W-1:0] i_o,
  output logic signed [W-1:0] q_o
);
  localparam int N  = 1 << LOG2N;
  localparam int K  = N + 2;          // data tap aligned to next-frame estimate
  localparam int DW = LOG2N + 1 + 2 * W;
  localparam int MW = PW + LOG2N + 1;

  logic                 last_pil;
  logic [LOG2N-1:0]     pos_q, pos_in;
  logic [DW-1:0]        dl [K+1];
  logic [LOG2N-1:0]     tp_pos;
  logic                 tp_pil;
  logic signed [W-1:0]  tp_i, tp_q;
  logic [PW-1:0]        est_old;
  logic signed [PW-1:0] delta;
  logic                 primed;
  logic signed [MW-1:0] prod, step;
  logic [PW-1:0]        i1_ph;
  logic signed [W-1:0]  i1_i, i1_q;
  logic                 i1_ok;

  assign pos_in = (pilot_i && !last_pil) ? '0 : pos_q + 1'b1;
  assign {tp_pos, tp_pil, tp_i, tp_q} = dl[K];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_pil <= 1'b0;
      pos_q    <= '0;
      for (int k = 0; k <= K; k++) dl[k] <= '0;
    end else if (valid_i) begin
      last_pil <= pilot_i;
      pos_q    <= pos_in;
      dl[0]    <= {pos_in, pilot_i, i_i, q_i};
      for (int k = 1; k <= K; k++) dl[k] <= dl[k-1];
    end
  end

  cr_pilot_est #(.W(W), .AB(AB), .PW(PW)) u_est (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(valid_i), .pilot_i(pilot_i),
    .i_i(i_i), .q_i(q_i),
    .est_old_o(est_old), .delta_o(delta), .primed_o(primed)
  );

  assign prod = delta * $signed({1'b0, tp_pos});
  assign step = prod >>> LOG2N;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i1_ph <= '0; i1_i <= '0; i1_q <= '0; i1_ok <= 1'b0;
    end else if (valid_i) begin
      i1_ph <= est_old + step[PW-1:0];
      i1_i  <= tp_i;
      i1_q  <= tp_q;
      i1_ok <= !tp_pil && primed;
    end
  end

  cr_derot #(.W(W), .PW(PW), .CW(CW)) u_rot (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(valid_i), .ok_i(i1_ok),
    .ph_i(i1_ph), .i_i(i1_i), .q_i(i1_q),
    .valid_o(valid_o), .i_o(i_o), .q_o(q_o)
  );
endmodule

// File: rtl/cr_pilot_phase_rec_chk.sv
module cr_pilot_phase_rec_chk #(
  parameter int W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic                pilot_i,
  input logic                valid_o,
  input logic signed [W-1:0] i_o,
  input logic signed [W-1:0] q_o
);
  logic        pil_d;
  int unsigned pairs, pay_in, outs;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pil_d <= 1'b0; pairs <= 0; pay_in <= 0; outs <= 0;
    end else begin
      if (valid_i) begin
        pil_d <= pilot_i;
        if (pilot_i && pil_d && pairs < 2) pairs <= pairs + 1;
        if (!pilot_i) pay_in <= pay_in + 1;
      end
      if (valid_o) outs <= outs + 1;
    end
  end

  // R6
  stall_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(valid_i));
  // R8
  hold_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(i_o) && $stable(q_o)));
  // R7
  primed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> pairs >= 2);
  // R7
  pilot_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> outs < pay_in);
endmodule

bind cr_pilot_phase_rec cr_pilot_phase_rec_chk #(.W(W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .pilot_i(pilot_i),
  .valid_o(valid_o), .i_o(i_o), .q_o(q_o)
);

// File: tb/cr_pilot_phase_rec_tb.sv
module cr_pilot_phase_rec_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8, AB = 5, PW = 10, CW = 10, LOG2N = 4;
  localparam int N = 1 << LOG2N;
  localparam int M = 1 << PW;
  localparam int LAT = N + 6;
  localparam int PRE = 5;
  localparam real PI = 3.14159265358979323846;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic valid_i = 1'b0, pilot_i = 1'b0;
  logic signed [W-1:0] i_i = '0, q_i = '0;
  logic valid_o;
  logic signed [W-1:0] i_o, q_o;

  int checks = 0, fails = 0;
  int si[$], sq[$];
  logic signed [W-1:0] last_i, last_q;

  always #(CLK_PERIOD/2) clk = ~clk;

  cr_pilot_phase_rec #(.W(W), .AB(AB), .PW(PW), .CW(CW), .LOG2N(LOG2N)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .pilot_i(pilot_i),
    .i_i(i_i), .q_i(q_i), .valid_o(valid_o), .i_o(i_o), .q_o(q_o)
  );

  function automatic int wrapm(int x); return ((x % M) + M) % M; endfunction
  function automatic int ws(int x);
    int w = wrapm(x);
    return (w >= M / 2) ? w - M : w;
  endfunction
  function automatic int rnd(real x); return $rtoi($floor(x + 0.5)); endfunction
  function automatic int satw(int x);
    if (x > (1 << (W-1)) - 1) return (1 << (W-1)) - 1;
    if (x < -(1 << (W-1))) return -(1 << (W-1));
    return x;
  endfunction

  // R2: coarse table phase minus pilot reference
  function automatic int ph_of(int j);
    int ih = si[j] >>> (W - AB);
    int qh = sq[j] >>> (W - AB);
    int a = rnd($atan2(2.0*qh + 1.0, 2.0*ih + 1.0) / PI * M / 2.0);
    return wrapm(a - M / 8);
  endfunction
  // R3: circular pair mean
  function automatic int est_of(int g);
    int a = ph_of(PRE + g*N);
    int b = ph_of(PRE + g*N + 1);
    return wrapm(a + (ws(b - a) >>> 1));
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, evaluate at the following negedge
  task automatic step_sym(bit v, bit p, int ii, int qq);
    int t, j, g, pos, e0, e1, ph, c, s;
    valid_i = v; pilot_i = p; i_i = W'(ii); q_i = W'(qq);
    @(posedge clk);
    @(negedge clk);
    if (v) begin
      si.push_back(ii); sq.push_back(qq);
      t = si.size() - 1;
      j = t - LAT;
      // R6 R7 R9: due symbol is payload of a frame (positions >= 2)
      if (j >= PRE && ((j - PRE) % N) >= 2) begin
        check("R6 valid due", int'(valid_o), 1);
        g = (j - PRE) / N; pos = (j - PRE) % N;
        e0 = est_of(g); e1 = est_of(g + 1);
        // R4 interpolation
        ph = wrapm(e0 + ((ws(e1 - e0) * pos) >>> LOG2N));
        c = rnd($cos(PI * ph / (M / 2)) * (1 << (CW-2)));
        s = rnd($sin(PI * ph / (M / 2)) * (1 << (CW-2)));
        // R5 derotation, rounding, saturation
        check("R5 i_o", int'(i_o), satw((si[j]*c + sq[j]*s + (1 << (CW-3))) >>> (CW-2)));
        check("R5 q_o", int'(q_o), satw((sq[j]*c - si[j]*s + (1 << (CW-3))) >>> (CW-2)));
      end else begin
        check("R7 no output for pilot/pre-lock symbol", int'(valid_o), 0);
      end
    end else begin
      check("R6 stall gives no output", int'(valid_o), 0);
    end
    if (!valid_o) begin
      check("R8 hold i_o", int'(i_o), int'(last_i));
      check("R8 hold q_o", int'(q_o), int'(last_q));
    end
    last_i = i_o; last_q = q_o;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; valid_i = 1'b0; pilot_i = 1'b0;
    si.delete(); sq.delete();
    repeat (3) @(negedge clk);
    check("R1 valid_o in reset", int'(valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 valid_o after reset", int'(valid_o), 0);
    check("R1 i_o after reset", int'(i_o), 0);
    check("R1 q_o after reset", int'(q_o), 0);
    last_i = i_o; last_q = q_o;
  endtask

  task automatic emit(bit p, real x, real y, real th);
    int ii = satw(rnd(x*$cos(th) - y*$sin(th)) + int'($urandom_range(0, 4)) - 2);
    int qq = satw(rnd(x*$sin(th) + y*$cos(th)) + int'($urandom_range(0, 4)) - 2);
    step_sym(1'b1, p, ii, qq);
  endtask

  // R9 frame layout: pilot pair then payload, PRE symbols of junk first
  task automatic run(int nfr, real th0, real rate, int gap_pct, real amp);
    real th = th0;
    real lv[4] = '{-3.0, -1.0, 1.0, 3.0};
    do_reset();
    for (int k = 0; k < PRE + nfr*N; k++) begin
      bit p = (k >= PRE) && (((k - PRE) % N) < 2);
      while (int'($urandom_range(0, 99)) < gap_pct)
        step_sym(1'b0, 1'b0, int'($urandom_range(0, 255)) - 128, 7);
      if (p) emit(1'b1, 60.0, 60.0, th);
      else emit(1'b0, amp*lv[$urandom_range(0, 3)], amp*lv[$urandom_range(0, 3)], th);
      th += rate;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    run(20, 0.2, 0.01, 0, 12.0);       // R2 R3 R4 slow drift
    run(24, PI - 0.3, 0.03, 25, 12.0); // R3 R4 wrap across +/-pi, R6 gaps
    run(8, -PI + 0.01, -0.02, 10, 12.0);
    run(10, 0.7, 0.0, 15, 40.0);       // R5 saturation with large symbols
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule